// File: doc/BRIEF.md
# Programmable Routing Switchbox

This block models the junction where a horizontal and a vertical routing channel cross. Four sides (north = 0, east = 1, south = 2, west = 3) each bring in four tracks and drive four tracks out. Any side can be joined to any of the other three sides. Two wiring patterns are available for each such join: a straight pattern, where source track t reaches destination track t, and a rotated pattern, where source track t reaches destination track (t+3) mod 4. Each possible join is controlled by one stored configuration bit.

The configuration bits sit in one shift chain. While `cfg_en` is high, one bit enters at `cfg_in` on every rising clock edge and the oldest bit leaves at `cfg_out`. Several boxes can be daisy-chained this way. While loading, every output is forced to 0. With `cfg_en` low the chain holds its contents and the box routes signals combinationally. A real routing wire is bidirectional. Here each destination track is modelled as the logical OR of every enabled source track that reaches it. The serial port has no back-pressure: a bit is taken on every edge at which `cfg_en` is high, so it carries no valid/ready handshake.

Top module: `route_switchbox`

## Requirements
- R1: An active-low `rst_n` clears every configuration bit. After reset, with `cfg_en` low, all of `trk_out` is 0 for any `trk_in`, and `cfg_out` is 0.
- R2: On each rising edge with `cfg_en` high, the chain shifts by one: `cfg_in` enters bit 0, bit i moves to bit i+1, and `cfg_out` always shows bit 95. The first bit shifted in therefore appears at `cfg_out` after 96 shifts. After 96 shifts, bit i of the chain holds the value presented on shift number 96-i (shifts counted from 1).
- R3: While `cfg_en` is high, every bit of `trk_out` is 0.
- R4: Bit b = ((s*3 + k)*4 + t)*2 + p selects a join. Here s is the source side, k in 0..2 makes the destination side d = (s+k+1) mod 4, t is the source track and p is the pattern. Track signals are packed as bit side*4 + track of `trk_in`/`trk_out`. When p = 0, a set bit drives `trk_out[d*4+t]` from `trk_in[s*4+t]`.
- R5: When p = 1, a set bit drives `trk_out[d*4+((t+3) mod 4)]` from `trk_in[s*4+t]`.
- R6: Each output track is the OR of all source tracks whose enable bits route them to it. With `trk_in` all zero, `trk_out` is all zero.
- R7: While `cfg_en` is low, the chain keeps its contents whatever `cfg_in` does. Both `cfg_out` and the routing stay unchanged.
- R8: No side's input reaches its own outputs. Even with every configuration bit set, an input active only on side s leaves `trk_out` of side s at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Active-low asynchronous reset of the chain |
| cfg_en | input | 1 | High: shift the chain and blank the outputs |
| cfg_in | input | 1 | Serial configuration bit entering the chain |
| cfg_out | output | 1 | Last bit of the chain, for daisy-chaining |
| trk_in | input | 16 | Incoming tracks, bit side*4+track |
| trk_out | output | 16 | Outgoing tracks, bit side*4+track |

## Verification
The assertions assume that `cfg_in` and `cfg_en` are stable around each rising edge, and that `trk_in` changes only combinationally, with no relation to the clock. The bench changes every input on the falling edge and samples half a cycle later. The shift check compares the chain's entry bit with the bit presented one edge earlier. It relies on no `cfg_in` transition coinciding with an edge. The bench keeps `cfg_en` low whenever it expects routed values, so the blanking property never conflicts with the routing comparisons.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SIDES = 4;
  localparam int PATS  = 2;
  localparam int OFFS  = SIDES - 1;

  function automatic int src_of(input int dst, input int k);
    return (dst + SIDES - k - 1) % SIDES;
  endfunction

  function automatic int bit_idx(input int s, input int k, input int t,
                                 input int p, input int tracks);
    return ((s * OFFS + k) * tracks + t) * PATS + p;
  endfunction

  function automatic int rot_src(input int j, input int p, input int tracks,
                                 input int rot);
    return (j + (tracks - (rot % tracks)) * p) % tracks;
  endfunction
endpackage

// File: rtl/sb_cfg_chain.sv
module sb_cfg_chain #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic         ser_out,
  output logic [W-1:0] bits
);
  logic [W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else if (shift_en) chain_q <= {chain_q[W-2:0], ser_in};
  end

  assign bits    = chain_q;
  assign ser_out = chain_q[W-1];
endmodule

// File: rtl/sb_dest_side.sv
module sb_dest_side #(
  parameter int TRACKS = 4,
  parameter int ROT    = 3,
  localparam int OFFS  = sb_pkg::OFFS,
  localparam int PATS  = sb_pkg::PATS
) (
  input  logic [OFFS*TRACKS-1:0]      src_trk,
  input  logic [OFFS*TRACKS*PATS-1:0] en,
  input  logic                        blank,
  output logic [TRACKS-1:0]           dst_trk
);
  for (genvar j = 0; j < TRACKS; j++) begin : g_trk
    logic [OFFS*PATS-1:0] term;
    for (genvar k = 0; k < OFFS; k++) begin : g_off
      for (genvar p = 0; p < PATS; p++) begin : g_pat
        localparam int T = sb_pkg::rot_src(j, p, TRACKS, ROT);
        assign term[k*PATS+p] = src_trk[k*TRACKS+T] & en[(k*TRACKS+T)*PATS+p];
      end
    end
    assign dst_trk[j] = (|term) & ~blank;
  end
endmodule

// File: rtl/route_switchbox.sv
module route_switchbox #(
  parameter int TRACKS = 4,
  parameter int ROT    = 3,
  localparam int SIDES = sb_pkg::SIDES,
  localparam int OFFS  = sb_pkg::OFFS,
  localparam int PATS  = sb_pkg::PATS,
  localparam int CFG_W = SIDES * OFFS * TRACKS * PATS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_en,
  input  logic                    cfg_in,
  output logic                    cfg_out,
  input  logic [SIDES*TRACKS-1:0] trk_in,
  output logic [SIDES*TRACKS-1:0] trk_out
);
  logic [CFG_W-1:0] cfg_bits;
  logic             chain_head;

  sb_cfg_chain #(.W(CFG_W)) chain_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .ser_in   (cfg_in),
    .ser_out  (cfg_out),
    .bits     (cfg_bits)
  );

  assign chain_head = cfg_bits[0];

  for (genvar d = 0; d < SIDES; d++) begin : g_dst
    logic [OFFS*TRACKS-1:0]      src_v;
    logic [OFFS*TRACKS*PATS-1:0] en_v;
    for (genvar k = 0; k < OFFS; k++) begin : g_k
      localparam int S = sb_pkg::src_of(d, k);
      for (genvar t = 0; t < TRACKS; t++) begin : g_t
        assign src_v[k*TRACKS+t] = trk_in[S*TRACKS+t];
        for (genvar p = 0; p < PATS; p++) begin : g_p
          assign en_v[(k*TRACKS+t)*PATS+p] = cfg_bits[sb_pkg::bit_idx(S, k, t, p, TRACKS)];
        end
      end
    end
    sb_dest_side #(.TRACKS(TRACKS), .ROT(ROT)) side_i (
      .src_trk (src_v),
      .en      (en_v),
      .blank   (cfg_en),
      .dst_trk (trk_out[d*TRACKS +: TRACKS])
    );
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_en,
  input logic         cfg_in,
  input logic         cfg_out,
  input logic         chain_head,
  input logic [N-1:0] trk_in,
  input logic [N-1:0] trk_out
);
  a_r3_blank_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (trk_out == '0));

  a_r2_entry_bit: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (chain_head == $past(cfg_in)));

  a_r7_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_out));

  a_r6_idle_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_in == '0) |-> (trk_out == '0));
endmodule

bind route_switchbox sb_checker #(.N(SIDES*TRACKS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_en     (cfg_en),
  .cfg_in     (cfg_in),
  .cfg_out    (cfg_out),
  .chain_head (chain_head),
  .trk_in     (trk_in),
  .trk_out    (trk_out)
);

// File: tb/route_switchbox_tb_top.sv
module route_switchbox_tb_top;
  localparam int T = 4, S = 4, NW = 96;

  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_in = 0;
  logic cfg_out;
  logic [15:0] trk_in = '0, trk_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  route_switchbox dut_i (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .cfg_out(cfg_out), .trk_in(trk_in), .trk_out(trk_out));

  function automatic logic [15:0] model(input logic [NW-1:0] c, input logic [15:0] x);
    logic [15:0] o = '0;
    for (int s = 0; s < S; s++)
      for (int k = 0; k < 3; k++)
        for (int t = 0; t < T; t++)
          for (int p = 0; p < 2; p++) begin
            int d = (s + k + 1) % S;
            int j = (t + 3 * p) % T;
            if (c[((s*3+k)*T+t)*2+p] && x[s*T+t]) o[d*T+j] = 1'b1;
          end
    return o;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [NW-1:0] v);
    cfg_en = 1;
    for (int i = NW - 1; i >= 0; i--) begin
      cfg_in = v[i];
      @(negedge clk);
    end
    cfg_en = 0;
    cfg_in = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NW-1:0] v;
    trk_in = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 outputs after reset", trk_out, 16'h0);
    chk("R1 cfg_out after reset", {15'h0, cfg_out}, 16'h0);

    // R4/R5 single-bit sweep with every one-hot source track
    for (int b = 0; b < NW; b++) begin
      load(NW'(1) << b);
      for (int x = 0; x < 16; x++) begin
        trk_in = 16'(1) << x;
        #1;
        chk((b % 2 == 0) ? "R4 straight join" : "R5 rotated join",
            trk_out, model(NW'(1) << b, trk_in));
      end
      @(negedge clk);
    end

    // R6 dense configurations, multi-driver OR
    for (int r = 0; r < 20; r++) begin
      for (int w = 0; w < 3; w++) v[w*32 +: 32] = $urandom;
      load(v);
      for (int q = 0; q < 8; q++) begin
        trk_in = 16'($urandom);
        #1;
        chk("R6 OR of drivers", trk_out, model(v, trk_in));
      end
      trk_in = '0;
      #1;
      chk("R6 zero inputs", trk_out, 16'h0);
      @(negedge clk);
    end

    // R8 own side isolated, all bits set
    load('1);
    for (int s = 0; s < S; s++) begin
      trk_in = 16'hF << (s*T);
      #1;
      chk("R8 own side dark", (trk_out >> (s*T)) & 16'hF, 16'h0);
      chk("R8 other sides", trk_out, model('1, trk_in));
    end
    @(negedge clk);

    // R3 blanking during load, R7 hold, R2 readout
    v = {32'hA5C3_0F17, 32'h1234_9876, 32'hDEAD_6B1E};
    trk_in = '1;
    cfg_en = 1;
    #1;
    chk("R3 blank while loading", trk_out, 16'h0);
    @(negedge clk);
    load(v);
    for (int i = 0; i < 6; i++) begin
      cfg_in = i[0];
      @(negedge clk);
    end
    trk_in = 16'h5A3C;
    #1;
    chk("R7 routing held", trk_out, model(v, trk_in));
    chk("R7 cfg_out held", {15'h0, cfg_out}, {15'h0, v[NW-1]});
    @(negedge clk);
    cfg_en = 1;
    for (int i = 0; i < NW; i++) begin
      chk("R2 serial out", {15'h0, cfg_out}, {15'h0, v[NW-1-i]});
      if (i == 10) chk("R3 blank mid shift", trk_out, 16'h0);
      cfg_in = 0;
      @(negedge clk);
    end
    cfg_en = 0;

    // R1 reset after full config
    load('1);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    trk_in = '1;
    #1;
    chk("R1 reset clears config", trk_out, 16'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule